// File: doc/BRIEF.md
# Interrupt Command Dispatcher to Per-CPU Pending Engines

This block sits between an interrupt translation command decoder and a row of per-CPU pending engines. The decoder hands it one command at a time. Each command carries an operation code, a mapped interrupt ID, a packed collection entry and two flags that say whether the translation entry and the collection entry were found valid. The block takes the target CPU from the collection entry and checks that it is in range. It then sends a one-cycle set-pending or clear-pending request, with the ID, to that CPU's engine.

A discard command also clears the mapping. The block pulses a strobe telling the translation table to zero the entry. Invalidate commands ask every engine, not only the first, to rescan its pending state and recompute its highest-priority interrupt. These recompute requests go out one CPU per cycle, from index 0 upward, under a valid/ready handshake. The dispatcher accepts no new command until the last engine has taken its request.

Top module: `lpi_cmd_dispatch`

## Requirements
- R1: The target index is the collection entry shifted right by one bit and then masked to PROC_W bits (bits PROC_W..1 of `cmd_cte`). Bit 0 and every bit above PROC_W have no effect on the target.
- R2: A target index equal to or above NUM_CPU drops the command. No pending request is made and `ite_zero` does not pulse.
- R3: Operation code 1 (interrupt command) and code 2 (doorbell write) cause a set request. In the cycle after acceptance, `pend_req_valid` is one-hot at the target CPU, `pend_req_level` is 1 and `pend_req_id` equals `cmd_id`, for exactly one cycle.
- R4: Operation code 3 (clear) and code 4 (discard) cause the same one-cycle request at the target CPU, with `pend_req_level` 0.
- R5: A discard that reaches an engine also pulses `ite_zero` in the same cycle as its clear request. No other operation code ever pulses `ite_zero`.
- R6: Operation code 5 (invalidate one) and code 6 (invalidate all) start a broadcast whatever the entry flags say. `rcmp_valid` is one-hot at CPU 0 in the cycle after acceptance. It holds while `rcmp_ready` for that CPU is low. After each handshake it moves to the next index, and after CPU NUM_CPU-1 it returns to zero.
- R7: `cmd_ready` is low from the cycle after an invalidate is accepted until the cycle after the last recompute handshake. A command held on the input meanwhile is taken only after that.
- R8: For codes 1 to 4, a command with either entry flag low makes no pending request and no `ite_zero` pulse.
- R9: Operation code 0 (no-op) and code 7 (reserved) produce no output activity and never stall.
- R10: After synchronous active-low reset, all request outputs and `ite_zero` are low and `cmd_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Dispatcher can take a command |
| cmd_op | input | 3 | Operation code (0 no-op, 1 interrupt, 2 doorbell, 3 clear, 4 discard, 5 invalidate, 6 invalidate all, 7 reserved) |
| cmd_id | input | ID_W | Mapped interrupt ID |
| cmd_ite_valid | input | 1 | Translation entry was found valid |
| cmd_cte_valid | input | 1 | Collection entry was found valid |
| cmd_cte | input | CTE_W | Packed collection entry |
| pend_req_valid | output | NUM_CPU | One-hot pending request, one bit per CPU engine |
| pend_req_level | output | 1 | 1 = set pending, 0 = clear pending |
| pend_req_id | output | ID_W | Interrupt ID of the pending request |
| ite_zero | output | 1 | Strobe to zero the translation entry |
| rcmp_valid | output | NUM_CPU | Priority-recompute request, one bit per CPU engine |
| rcmp_ready | input | NUM_CPU | Engine accepts the recompute request |

## Verification
The bench puts junk in collection-entry bit 0 and in the bits above the processor field. A design that shifted wrongly or did not mask would pick the wrong CPU. It sends a target index exactly equal to the CPU count, which a greater-than-only range test would let reach a nonexistent engine. It stalls one engine in the middle of a broadcast while a set command waits on the input. A design that broadcast only to CPU 0, skipped a stalled engine, or let the waiting command slip past would show the wrong `rcmp_valid` walk or an early pending request. Discards with missing entries or an out-of-range target check that the mapping is not zeroed when nothing was dispatched.

// File: rtl/lpi_disp_pkg.sv
// Package: shared operation encodings and the per-command action bundle
// for the interrupt command dispatcher.
package lpi_disp_pkg;

    // Operation codes presented by the command decoder.
    typedef enum logic [2:0] {
        OP_NOP      = 3'd0,
        OP_INT      = 3'd1,
        OP_DOORBELL = 3'd2,
        OP_CLEAR    = 3'd3,
        OP_DISCARD  = 3'd4,
        OP_INV      = 3'd5,
        OP_INVALL   = 3'd6,
        OP_RSVD     = 3'd7
    } disp_op_e;

    // Actions one accepted command may cause.
    typedef struct packed {
        logic do_set;    // set-pending request to the target engine
        logic do_clr;    // clear-pending request to the target engine
        logic do_zap;    // zero the translation entry
        logic do_bcast;  // recompute on every engine
    } disp_act_t;

endpackage

// File: rtl/disp_target_sel.sv
// Module: disp_target_sel
// Pulls the processor-number field out of a packed collection entry and
// range-checks it against the configured CPU count.
// Assumes: PROC_W + 1 <= CTE_W, PROC_W >= IDX_W and PROC_W < 31.
module disp_target_sel #(
    parameter int CTE_W   = 32,
    parameter int PROC_W  = 4,
    parameter int NUM_CPU = 4,
    parameter int IDX_W   = 2
) (
    input  logic [CTE_W-1:0] cte,
    output logic [IDX_W-1:0] idx,
    output logic             in_range
);

    localparam logic [PROC_W-1:0] FIELD_MASK = {PROC_W{1'b1}};

    logic [CTE_W-1:0]  shifted;
    logic [PROC_W-1:0] field;

    // Shift off the valid bit, then keep only the processor-number field.
    always_comb begin
        shifted  = cte >> 1;
        field    = shifted[PROC_W-1:0] & FIELD_MASK;
        in_range = (int'(field) < NUM_CPU);
        idx      = field[IDX_W-1:0];
    end

endmodule

// File: rtl/disp_op_class.sv
// Module: disp_op_class
// Turns an operation code plus the entry-valid flags and the range result
// into the set of actions the dispatcher performs.
// Assumes: the inputs are only meaningful in a cycle where a command is accepted.
module disp_op_class
    import lpi_disp_pkg::*;
(
    input  logic [2:0] op,
    input  logic       ite_ok,
    input  logic       cte_ok,
    input  logic       in_range,
    output disp_act_t  act
);

    disp_op_e op_e;
    logic     routable;

    // Decode the code and gate the per-CPU actions on valid, in-range entries.
    always_comb begin
        op_e         = disp_op_e'(op);
        routable     = ite_ok && cte_ok && in_range;
        act          = '0;
        unique case (op_e)
            OP_INT, OP_DOORBELL: act.do_set = routable;
            OP_CLEAR:            act.do_clr = routable;
            OP_DISCARD: begin
                act.do_clr = routable;
                act.do_zap = routable;
            end
            OP_INV, OP_INVALL:   act.do_bcast = 1'b1;
            default:             act = '0;
        endcase
    end

endmodule

// File: rtl/disp_bcast_seq.sv
// Module: disp_bcast_seq
// Walks a recompute request across all engines, one engine per cycle,
// holding each request until that engine raises ready.
// Assumes: start is only asserted while busy is low.
module disp_bcast_seq #(
    parameter int NUM_CPU = 4,
    parameter int IDX_W   = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [NUM_CPU-1:0] rcmp_ready,
    output logic               busy,
    output logic [NUM_CPU-1:0] rcmp_valid
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_CPU - 1);

    logic [IDX_W-1:0] cur;
    logic             fire;
    logic             last;

    // One-hot request decoded from the walk position.
    for (genvar g = 0; g < NUM_CPU; g++) begin : g_req
        assign rcmp_valid[g] = busy && (cur == IDX_W'(g));
    end

    // Handshake on the currently addressed engine.
    always_comb begin
        fire = |(rcmp_valid & rcmp_ready);
        last = (cur == LAST_IDX);
    end

    // Walk state: start at engine 0, advance on handshake, stop after the last.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
            cur  <= '0;
        end else if (start) begin
            busy <= 1'b1;
            cur  <= '0;
        end else if (fire) begin
            if (last) begin
                busy <= 1'b0;
                cur  <= '0;
            end else begin
                cur  <= cur + 1'b1;
            end
        end
    end

    AST_RCMP_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(rcmp_valid)); // R6
    AST_RCMP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !fire) |=> $stable(rcmp_valid)); // R6
    AST_RCMP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && !last) |=> (rcmp_valid == ($past(rcmp_valid) << 1))); // R6
    AST_BCAST_END: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && last) |=> (rcmp_valid == '0)); // R7

endmodule

// File: rtl/disp_pend_issue.sv
// Module: disp_pend_issue
// Registers the one-cycle set/clear pending request toward the target
// engine and the translation-entry zeroing strobe.
// Assumes: do_set and do_clr are never both high.
module disp_pend_issue #(
    parameter int NUM_CPU = 4,
    parameter int IDX_W   = 2,
    parameter int ID_W    = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               do_set,
    input  logic               do_clr,
    input  logic               do_zap,
    input  logic [IDX_W-1:0]   idx,
    input  logic [ID_W-1:0]    id,
    output logic [NUM_CPU-1:0] pend_valid,
    output logic               pend_level,
    output logic [ID_W-1:0]    pend_id,
    output logic               ite_zero
);

    logic               hit;
    logic [NUM_CPU-1:0] sel;

    // Decode the target index into a per-engine select.
    for (genvar g = 0; g < NUM_CPU; g++) begin : g_sel
        assign sel[g] = hit && (idx == IDX_W'(g));
    end

    // Any pending action this cycle.
    always_comb hit = do_set || do_clr;

    // Request registers: a pulse of one cycle per dispatched command.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_valid <= '0;
            pend_level <= 1'b0;
            pend_id    <= '0;
            ite_zero   <= 1'b0;
        end else begin
            pend_valid <= sel;
            pend_level <= do_set;
            pend_id    <= hit ? id : '0;
            ite_zero   <= do_zap;
        end
    end

    AST_PEND_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(pend_valid)); // R3
    AST_ZERO_WITH_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        ite_zero |-> ((pend_valid != '0) && !pend_level)); // R5

endmodule

// File: rtl/lpi_cmd_dispatch.sv
// Module: lpi_cmd_dispatch (top)
// Takes translated interrupt commands and routes set/clear pending
// requests, translation-entry zeroing and broadcast recompute requests
// to a row of per-CPU pending engines.
// Assumes: pending engines always take a pending request; recompute
// requests use a valid/ready handshake per engine.
module lpi_cmd_dispatch
    import lpi_disp_pkg::*;
#(
    parameter int NUM_CPU = 4,
    parameter int ID_W    = 16,
    parameter int CTE_W   = 32,
    parameter int PROC_W  = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cmd_valid,
    output logic               cmd_ready,
    input  logic [2:0]         cmd_op,
    input  logic [ID_W-1:0]    cmd_id,
    input  logic               cmd_ite_valid,
    input  logic               cmd_cte_valid,
    input  logic [CTE_W-1:0]   cmd_cte,
    output logic [NUM_CPU-1:0] pend_req_valid,
    output logic               pend_req_level,
    output logic [ID_W-1:0]    pend_req_id,
    output logic               ite_zero,
    output logic [NUM_CPU-1:0] rcmp_valid,
    input  logic [NUM_CPU-1:0] rcmp_ready
);

    localparam int IDX_W = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1;

    logic             accept;
    logic             busy;
    logic             in_range;
    logic [IDX_W-1:0] tgt_idx;
    disp_act_t        act;
    disp_act_t        act_q;

    // Handshake: commands are taken whenever no broadcast is running.
    always_comb begin
        cmd_ready = !busy;
        accept    = cmd_valid && cmd_ready;
    end

    disp_target_sel #(
        .CTE_W  (CTE_W),
        .PROC_W (PROC_W),
        .NUM_CPU(NUM_CPU),
        .IDX_W  (IDX_W)
    ) u_tsel (
        .cte     (cmd_cte),
        .idx     (tgt_idx),
        .in_range(in_range)
    );

    disp_op_class u_cls (
        .op      (cmd_op),
        .ite_ok  (cmd_ite_valid),
        .cte_ok  (cmd_cte_valid),
        .in_range(in_range),
        .act     (act)
    );

    // Qualify the decoded actions with acceptance.
    always_comb act_q = accept ? act : '0;

    disp_pend_issue #(
        .NUM_CPU(NUM_CPU),
        .IDX_W  (IDX_W),
        .ID_W   (ID_W)
    ) u_pend (
        .clk       (clk),
        .rst_n     (rst_n),
        .do_set    (act_q.do_set),
        .do_clr    (act_q.do_clr),
        .do_zap    (act_q.do_zap),
        .idx       (tgt_idx),
        .id        (cmd_id),
        .pend_valid(pend_req_valid),
        .pend_level(pend_req_level),
        .pend_id   (pend_req_id),
        .ite_zero  (ite_zero)
    );

    disp_bcast_seq #(
        .NUM_CPU(NUM_CPU),
        .IDX_W  (IDX_W)
    ) u_bcast (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (act_q.do_bcast),
        .rcmp_ready(rcmp_ready),
        .busy      (busy),
        .rcmp_valid(rcmp_valid)
    );

    AST_DROP_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !in_range) |=> ((pend_req_valid == '0) && !ite_zero)); // R2
    AST_NO_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !(cmd_ite_valid && cmd_cte_valid)) |=> ((pend_req_valid == '0) && !ite_zero)); // R8
    AST_STALL_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (rcmp_valid != '0) |-> !cmd_ready); // R7
    AST_ZERO_DISCARD: assert property (@(posedge clk) disable iff (!rst_n)
        ite_zero |-> $past(accept && (cmd_op == 3'd4))); // R5
    AST_BCAST_START: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && ((cmd_op == 3'd5) || (cmd_op == 3'd6))) |=> rcmp_valid[0]); // R6

endmodule

// File: tb/tb_lpi_cmd_dispatch.sv
`timescale 1ns/1ps
module tb_lpi_cmd_dispatch;

    localparam int NUM_CPU = 4;
    localparam int ID_W    = 16;
    localparam int CTE_W   = 32;
    localparam int PROC_W  = 4;
    localparam int NVEC    = 12;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               cmd_valid = 1'b0;
    logic               cmd_ready;
    logic [2:0]         cmd_op = '0;
    logic [ID_W-1:0]    cmd_id = '0;
    logic               cmd_ite_valid = 1'b0;
    logic               cmd_cte_valid = 1'b0;
    logic [CTE_W-1:0]   cmd_cte = '0;
    logic [NUM_CPU-1:0] pend_req_valid;
    logic               pend_req_level;
    logic [ID_W-1:0]    pend_req_id;
    logic               ite_zero;
    logic [NUM_CPU-1:0] rcmp_valid;
    logic [NUM_CPU-1:0] rcmp_ready = '1;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk; // 125 MHz

    lpi_cmd_dispatch #(
        .NUM_CPU(NUM_CPU), .ID_W(ID_W), .CTE_W(CTE_W), .PROC_W(PROC_W)
    ) dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_op(cmd_op), .cmd_id(cmd_id), .cmd_ite_valid(cmd_ite_valid),
        .cmd_cte_valid(cmd_cte_valid), .cmd_cte(cmd_cte),
        .pend_req_valid(pend_req_valid), .pend_req_level(pend_req_level),
        .pend_req_id(pend_req_id), .ite_zero(ite_zero),
        .rcmp_valid(rcmp_valid), .rcmp_ready(rcmp_ready)
    );

    // Layout: op[58:56] id[55:40] ite[39] cte_ok[38] cte[37:6] exp_pv[5:2] exp_lvl[1] exp_zero[0]
    localparam logic [58:0] VEC [NVEC] = '{
        {3'd1, 16'h0123, 1'b1, 1'b1, 32'h0000_0005, 4'b0100, 1'b1, 1'b0}, // R3 interrupt to CPU2
        {3'd2, 16'h0456, 1'b1, 1'b1, 32'h0000_0000, 4'b0001, 1'b1, 1'b0}, // R3 doorbell to CPU0
        {3'd3, 16'h0789, 1'b1, 1'b1, 32'h0000_0006, 4'b1000, 1'b0, 1'b0}, // R4 clear CPU3
        {3'd4, 16'h0ABC, 1'b1, 1'b1, 32'h0000_0003, 4'b0010, 1'b0, 1'b1}, // R5 discard CPU1
        {3'd1, 16'h0DEF, 1'b1, 1'b1, 32'hFFFF_FFE3, 4'b0010, 1'b1, 1'b0}, // R1 junk bits -> CPU1
        {3'd1, 16'h0111, 1'b1, 1'b1, 32'h0000_0008, 4'b0000, 1'b0, 1'b0}, // R2 index == NUM_CPU
        {3'd4, 16'h0222, 1'b1, 1'b1, 32'h0000_001E, 4'b0000, 1'b0, 1'b0}, // R2 index 15 discard
        {3'd1, 16'h0333, 1'b0, 1'b1, 32'h0000_0002, 4'b0000, 1'b0, 1'b0}, // R8 no translation
        {3'd3, 16'h0444, 1'b1, 1'b0, 32'h0000_0002, 4'b0000, 1'b0, 1'b0}, // R8 no collection
        {3'd4, 16'h0555, 1'b0, 1'b1, 32'h0000_0002, 4'b0000, 1'b0, 1'b0}, // R8 discard unmapped
        {3'd0, 16'h0666, 1'b1, 1'b1, 32'h0000_0002, 4'b0000, 1'b0, 1'b0}, // R9 no-op
        {3'd7, 16'h0777, 1'b1, 1'b1, 32'h0000_0002, 4'b0000, 1'b0, 1'b0}  // R9 reserved
    };

    function automatic string vec_tag(int i);
        case (i)
            0, 1:       return "R3";
            2:          return "R4";
            3:          return "R5";
            4:          return "R1";
            5, 6:       return "R2";
            7, 8, 9:    return "R8";
            default:    return "R9";
        endcase
    endfunction

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    // Drive one command at a negedge, accept it at the posedge, check at the next negedge.
    task automatic send(input logic [2:0] op, input logic [ID_W-1:0] id,
                        input logic iv, input logic cv, input logic [CTE_W-1:0] cte);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op; cmd_id = id;
        cmd_ite_valid = iv; cmd_cte_valid = cv; cmd_cte = cte;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    initial begin
        #(8 * 100000);
        checks++;
        errors++;
        $display("FAIL watchdog: run did not complete");
        finish_run();
    end

    initial begin
        repeat (4) @(negedge clk);
        // R10: state while and after reset
        rst_n = 1'b1;
        @(negedge clk);
        check(cmd_ready == 1'b1, "R10", "cmd_ready after reset", 32'(cmd_ready), 32'd1);
        check(pend_req_valid == '0 && !ite_zero, "R10", "pending/zero after reset",
              32'({pend_req_valid, ite_zero}), 32'd0);
        check(rcmp_valid == '0, "R10", "rcmp_valid after reset", 32'(rcmp_valid), 32'd0);

        // Table-driven pass
        for (int i = 0; i < NVEC; i++) begin
            logic [58:0] v;
            v = VEC[i];
            send(v[58:56], v[55:40], v[39], v[38], v[37:6]);
            check(pend_req_valid == v[5:2], vec_tag(i), $sformatf("vec %0d pend_req_valid", i),
                  32'(pend_req_valid), 32'(v[5:2]));
            if (v[5:2] != '0) begin
                check(pend_req_level == v[1], vec_tag(i), $sformatf("vec %0d level", i),
                      32'(pend_req_level), 32'(v[1]));
                check(pend_req_id == v[55:40], vec_tag(i), $sformatf("vec %0d id", i),
                      32'(pend_req_id), 32'(v[55:40]));
            end
            check(ite_zero == v[0], vec_tag(i), $sformatf("vec %0d ite_zero", i),
                  32'(ite_zero), 32'(v[0]));
            check(cmd_ready && rcmp_valid == '0, "R9", $sformatf("vec %0d no stall", i),
                  32'({cmd_ready, rcmp_valid}), 32'h10);
        end

        // R3: request lasts one cycle only
        send(3'd1, 16'h00AA, 1'b1, 1'b1, 32'h2);
        @(negedge clk);
        check(pend_req_valid == '0, "R3", "pulse gone next cycle", 32'(pend_req_valid), 32'd0);

        // R6/R7: invalidate broadcast with all engines ready, entries invalid
        send(3'd5, 16'h0000, 1'b0, 1'b0, 32'h0);
        for (int c = 0; c < NUM_CPU; c++) begin
            check(rcmp_valid == NUM_CPU'(1 << c), "R6", $sformatf("inv walk step %0d", c),
                  32'(rcmp_valid), 32'(1 << c));
            check(cmd_ready == 1'b0, "R7", $sformatf("inv ready low step %0d", c),
                  32'(cmd_ready), 32'd0);
            if (c < NUM_CPU - 1) @(negedge clk);
        end
        @(negedge clk);
        check(rcmp_valid == '0 && cmd_ready, "R7", "inv done, ready back",
              32'({cmd_ready, rcmp_valid}), 32'h10);

        // R6/R7: invalidate-all with engine 1 stalled and a set command waiting
        rcmp_ready = 4'b1101;
        send(3'd6, 16'h0000, 1'b1, 1'b1, 32'h0);
        check(rcmp_valid == 4'b0001, "R6", "invall first engine", 32'(rcmp_valid), 32'h1);
        cmd_valid = 1'b1; cmd_op = 3'd1; cmd_id = 16'h0BEE;
        cmd_ite_valid = 1'b1; cmd_cte_valid = 1'b1; cmd_cte = 32'h5;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            check(rcmp_valid == 4'b0010, "R6", $sformatf("stall hold %0d", k),
                  32'(rcmp_valid), 32'h2);
            check(!cmd_ready && pend_req_valid == '0, "R7", $sformatf("waiting cmd blocked %0d", k),
                  32'({cmd_ready, pend_req_valid}), 32'h0);
        end
        rcmp_ready = '1;
        @(negedge clk);
        check(rcmp_valid == 4'b0100, "R6", "resume engine 2", 32'(rcmp_valid), 32'h4);
        @(negedge clk);
        check(rcmp_valid == 4'b1000, "R6", "resume engine 3", 32'(rcmp_valid), 32'h8);
        @(negedge clk);
        check(rcmp_valid == '0 && cmd_ready && pend_req_valid == '0, "R7", "walk end, cmd not yet taken",
              32'({cmd_ready, rcmp_valid, pend_req_valid}), 32'h100);
        @(negedge clk);
        cmd_valid = 1'b0;
        check(pend_req_valid == 4'b0100 && pend_req_level, "R7", "held cmd taken after walk",
              32'({pend_req_level, pend_req_valid}), 32'h14);

        @(negedge clk);
        finish_run();
    end

endmodule